// File: doc/BRIEF.md
# Buffered FIFO Silo Datapath

This block is the data buffer of a mass-storage controller. It sits between a host side that moves words by direct memory access at irregular times and a device data bus that moves words at a steady rate. Every word, in either direction, enters through an input holding register, ripples through a chain of storage cells and leaves through an output holding register. With the default 64 cells this gives 66 words of buffering. Words move one cell toward the output on each clock when the next cell is empty, so order is preserved. Because the path is the same for every word, software can write a word at the input and read it back at the output as a maintenance test of the storage.

A direction input selects which side feeds the buffer. When the host feeds the device, the output is held back until the buffer is full or the host has delivered its whole transfer. This lets the buffer fill before the device bus starts moving words. Two word counters are loaded together with the same two's-complement count. One steps on host-side transfers and the other on device-side transfers. The device-side counter marks the end of the transfer, so the controller stays busy while the buffer drains after the host count has already wrapped.

Top module: `silo_datapath`

## Requirements
- R1: After reset, ibuf_full_o, obuf_full_o, silo_out_rdy_o, out_valid_o, host_ovf_o and dev_done_o are 0, and silo_in_rdy_o is 1.
- R2: Words leave on out_data_o in the order they were accepted, each with all DATA_W bits unchanged. A word shown with out_valid_o high stays stable until it is taken with out_take_i.
- R3: With nothing taken at the output, exactly DEPTH+2 words are accepted. After that, ibuf_full_o stays 1.
- R4: A word is accepted only when in_valid_i is 1 and ibuf_full_o is 0. A word presented while ibuf_full_o is 1 is dropped and never reaches the output.
- R5: silo_in_rdy_o is 1 when the first storage cell is empty. silo_out_rdy_o is 1 when the last storage cell holds a word. With the buffer full, these read 0 and 1.
- R6: A word accepted at a clock edge into an empty buffer raises out_valid_o at the DEPTH+1-th following edge, and not before.
- R7: out_take_i while out_valid_o is 0 has no effect. A later word still arrives intact and on time.
- R8: With dev_write_i=1 (host to device), out_valid_o stays 0 until all DEPTH+2 places hold words or host_ovf_o is 1. It stays high from then until the next count load or clear.
- R9: wc_load_i loads wc_value_i, the two's complement of a word count N, into both counters. dev_done_o rises on the N-th device-side transfer: a taken output word when dev_write_i=1, an accepted input word when dev_write_i=0.
- R10: host_ovf_o rises on the N-th host-side transfer: an accepted input word when dev_write_i=1, a taken output word when dev_write_i=0. In a host-to-device transfer larger than the buffer, it rises while dev_done_o is still 0.
- R11: clr_i empties both holding registers and every cell, drops host_ovf_o and dev_done_o on the next edge, and words stored before it never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of buffer and counter flags |
| dev_write_i | input | 1 | 1: host feeds device; 0: device feeds host |
| wc_load_i | input | 1 | Load both word counters |
| wc_value_i | input | CNT_W | Two's complement of the transfer length |
| in_valid_i | input | 1 | Word offered at the input |
| in_data_i | input | DATA_W | Input word |
| ibuf_full_o | output | 1 | Input holding register occupied |
| silo_in_rdy_o | output | 1 | First storage cell empty |
| silo_out_rdy_o | output | 1 | Last storage cell occupied |
| obuf_full_o | output | 1 | Output holding register occupied |
| out_valid_o | output | 1 | Output word may be taken |
| out_take_i | input | 1 | Take the output word |
| out_data_o | output | DATA_W | Output word |
| host_ovf_o | output | 1 | Host-side count has wrapped |
| dev_done_o | output | 1 | Device-side count has wrapped |

## Verification
The bench builds the block with its defaults: 18-bit words, 64 cells and 16-bit counters. This makes the full 66-word capacity, the 65-edge fall-through latency and the prefill hold all reachable at their real sizes. Small word counts loaded as two's complements let the bench compare a transfer longer than the buffer against one that ends before the buffer fills. In the longer one, the host count wraps well before the device count. In the shorter one, the host wrap alone must release the output.

// File: rtl/silo_pkg.sv
package silo_pkg;
  localparam int unsigned HOLD_STAGES = 2;

  typedef enum logic {
    DIR_DEV_TO_HOST = 1'b0,
    DIR_HOST_TO_DEV = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/silo_hold_reg.sv
module silo_hold_reg #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              unload_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       full_q <= 1'b0;
    else if (clr_i)    full_q <= 1'b0;
    else if (load_i)   full_q <= 1'b1;
    else if (unload_i) full_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (load_i) data_q <= data_i;
  end

  assign full_o = full_q;
  assign data_o = data_q;

  p_hold_no_overwrite_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !full_o);
endmodule

// File: rtl/silo_shift_array.sv
module silo_shift_array #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              head_empty_o,
  output logic              tail_valid_o,
  output logic [DATA_W-1:0] tail_data_o,
  output logic              all_full_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  mv;      // cell hands its word onward this cycle
  logic [DEPTH-1:0]  arrive;  // cell receives a word this cycle
  logic [DATA_W-1:0] dat_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    if (i == LAST) begin : g_tail
      assign mv[i] = pop_i;
    end else begin : g_mid
      assign mv[i] = vld_q[i] && !vld_q[i+1];
    end

    if (i == 0) begin : g_head
      assign arrive[i] = push_i;
      always_ff @(posedge clk_i) begin
        if (arrive[i]) dat_q[i] <= push_data_i;
      end
    end else begin : g_body
      assign arrive[i] = mv[i-1];
      always_ff @(posedge clk_i) begin
        if (arrive[i]) dat_q[i] <= dat_q[i-1];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_q[i] <= 1'b0;
      else if (clr_i) vld_q[i] <= 1'b0;
      else            vld_q[i] <= (vld_q[i] && !mv[i]) || arrive[i];
    end
  end

  assign head_empty_o = !vld_q[0];
  assign tail_valid_o = vld_q[LAST];
  assign tail_data_o  = dat_q[LAST];
  assign all_full_o   = &vld_q;

  p_push_head_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> head_empty_o);
  p_pop_tail_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> tail_valid_o);
  p_tail_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_valid_o && !pop_i && !clr_i |=> tail_valid_o);
endmodule

// File: rtl/silo_word_counter.sv
module silo_word_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic             wrapped_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr_i) begin
      wrap_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      wrap_q <= 1'b0;
    end else if (step_i) begin
      cnt_q <= cnt_q + ONE;
      if (&cnt_q) wrap_q <= 1'b1;
    end
  end

  assign wrapped_o = wrap_q;

  p_wrap_on_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrapped_o) |-> $past(step_i));
endmodule

// File: rtl/silo_datapath.sv
module silo_datapath
  import silo_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              dev_write_i,
  input  logic              wc_load_i,
  input  logic [CNT_W-1:0]  wc_value_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              ibuf_full_o,
  output logic              silo_in_rdy_o,
  output logic              silo_out_rdy_o,
  output logic              obuf_full_o,
  output logic              out_valid_o,
  input  logic              out_take_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              host_ovf_o,
  output logic              dev_done_o
);
  localparam int unsigned CAPACITY = DEPTH + HOLD_STAGES;

  xfer_dir_e         dir;
  logic              push_acc, pop_acc, ib_to_arr, arr_to_ob;
  logic              ibuf_full, obuf_full, arr_head_empty, arr_tail_valid, arr_full;
  logic [DATA_W-1:0] ibuf_data, arr_tail_data;
  logic              started_q, all_words;
  logic              host_step, dev_step;

  assign dir       = dev_write_i ? DIR_HOST_TO_DEV : DIR_DEV_TO_HOST;
  assign push_acc  = in_valid_i && !ibuf_full;
  assign ib_to_arr = ibuf_full && arr_head_empty;
  assign arr_to_ob = arr_tail_valid && !obuf_full;
  assign pop_acc   = out_take_i && out_valid_o;

  silo_hold_reg #(.DATA_W(DATA_W)) u_ibuf (
    .clk_i, .rst_ni, .clr_i,
    .load_i(push_acc), .data_i(in_data_i), .unload_i(ib_to_arr),
    .full_o(ibuf_full), .data_o(ibuf_data)
  );

  silo_shift_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk_i, .rst_ni, .clr_i,
    .push_i(ib_to_arr), .push_data_i(ibuf_data), .pop_i(arr_to_ob),
    .head_empty_o(arr_head_empty), .tail_valid_o(arr_tail_valid),
    .tail_data_o(arr_tail_data), .all_full_o(arr_full)
  );

  silo_hold_reg #(.DATA_W(DATA_W)) u_obuf (
    .clk_i, .rst_ni, .clr_i,
    .load_i(arr_to_ob), .data_i(arr_tail_data), .unload_i(pop_acc),
    .full_o(obuf_full), .data_o(out_data_o)
  );

  // all CAPACITY places occupied
  assign all_words = ibuf_full && arr_full && obuf_full;

  // host-to-device: hold the device side until prefill completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           started_q <= 1'b0;
    else if (clr_i || wc_load_i)                           started_q <= 1'b0;
    else if (dir == DIR_HOST_TO_DEV && (all_words || host_ovf_o)) started_q <= 1'b1;
  end

  assign out_valid_o = obuf_full && (dir == DIR_DEV_TO_HOST || started_q);

  assign host_step = (dir == DIR_HOST_TO_DEV) ? push_acc : pop_acc;
  assign dev_step  = (dir == DIR_HOST_TO_DEV) ? pop_acc  : push_acc;

  silo_word_counter #(.CNT_W(CNT_W)) u_host_wc (
    .clk_i, .rst_ni, .clr_i,
    .load_i(wc_load_i), .load_val_i(wc_value_i), .step_i(host_step),
    .wrapped_o(host_ovf_o)
  );

  silo_word_counter #(.CNT_W(CNT_W)) u_dev_wc (
    .clk_i, .rst_ni, .clr_i,
    .load_i(wc_load_i), .load_val_i(wc_value_i), .step_i(dev_step),
    .wrapped_o(dev_done_o)
  );

  assign ibuf_full_o    = ibuf_full;
  assign obuf_full_o    = obuf_full;
  assign silo_in_rdy_o  = arr_head_empty;
  assign silo_out_rdy_o = arr_tail_valid;

  initial begin
    a_capacity_r3: assert (CAPACITY == DEPTH + 2);
  end

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_take_i && !clr_i && !wc_load_i |=> out_valid_o && $stable(out_data_o));
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ibuf_full_o && !obuf_full_o && silo_in_rdy_o && !host_ovf_o && !dev_done_o);
endmodule

// File: tb/silo_datapath_tb.sv
`timescale 1ns/1ps
module silo_datapath_tb;
  localparam int DW = 18;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clr_i = 1'b0, dev_write_i = 1'b0, wc_load_i = 1'b0;
  logic [CW-1:0] wc_value_i = '0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          out_take_i = 1'b0;
  logic          ibuf_full_o, silo_in_rdy_o, silo_out_rdy_o, obuf_full_o;
  logic          out_valid_o, host_ovf_o, dev_done_o;
  logic [DW-1:0] out_data_o;

  int errors = 0, checks = 0;
  logic [DW-1:0] q[$];
  bit drain_en = 0, spurious_take = 0;

  always #2.5 clk_i = ~clk_i;

  silo_datapath u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (drain_en && out_valid_o) begin
      if (q.size() == 0) chk(0, "R4 unexpected word at output", 32'(out_data_o), 0);
      else begin
        logic [DW-1:0] e;
        e = q.pop_front();
        chk(out_data_o == e, "R2 order/data", 32'(out_data_o), 32'(e));
      end
      out_take_i <= 1'b1;
    end else out_take_i <= spurious_take;
  end

  task automatic push_word(input logic [DW-1:0] w);
    int n = 0;
    @(negedge clk_i);
    while (ibuf_full_o && n < 1000) begin @(negedge clk_i); n++; end
    if (ibuf_full_o) chk(0, "R4 input stalled", 1, 0);
    in_valid_i = 1'b1; in_data_i = w; q.push_back(w);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic load_wc(input int n);
    @(negedge clk_i);
    wc_load_i = 1'b1; wc_value_i = '0 - CW'(n);
    @(negedge clk_i);
    wc_load_i = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int n = 0;
    while (q.size() != 0 && n < 3000) begin @(negedge clk_i); n++; end
    chk(q.size() == 0, req, q.size(), 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(!ibuf_full_o, "R1 ibuf_full", ibuf_full_o, 0);
    chk(!obuf_full_o, "R1 obuf_full", obuf_full_o, 0);
    chk(silo_in_rdy_o, "R1 silo_in_rdy", silo_in_rdy_o, 1);
    chk(!silo_out_rdy_o, "R1 silo_out_rdy", silo_out_rdy_o, 0);
    chk(!out_valid_o, "R1 out_valid", out_valid_o, 0);
    chk(!host_ovf_o && !dev_done_o, "R1 counter flags", {host_ovf_o, dev_done_o}, 0);

    // R6 latency, R7 spurious takes while empty
    spurious_take = 1;
    push_word(18'h2_5A5A);
    repeat (10) @(negedge clk_i);
    spurious_take = 0;
    repeat (54) @(negedge clk_i);
    chk(!out_valid_o, "R6 valid too early", out_valid_o, 0);
    @(negedge clk_i);
    chk(out_valid_o, "R6 valid at DEPTH+1", out_valid_o, 1);
    chk(out_data_o == 18'h2_5A5A, "R7 word intact after spurious takes", 32'(out_data_o), 32'h2_5A5A);
    drain_en = 1;
    wait_drain("R2 single word");

    // R3/R4/R5 capacity
    drain_en = 0;
    for (int i = 0; i < 66; i++) push_word(DW'(i * 1031 + 7));
    repeat (150) @(negedge clk_i);
    chk(ibuf_full_o, "R3 ibuf full at capacity", ibuf_full_o, 1);
    chk(obuf_full_o, "R3 obuf full at capacity", obuf_full_o, 1);
    chk(!silo_in_rdy_o, "R5 silo_in_rdy when full", silo_in_rdy_o, 0);
    chk(silo_out_rdy_o, "R5 silo_out_rdy when full", silo_out_rdy_o, 1);
    in_valid_i = 1'b1; in_data_i = 18'h3_FFFF;
    repeat (3) @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(ibuf_full_o, "R3 still full", ibuf_full_o, 1);
    drain_en = 1;
    wait_drain("R3 drain 66");
    repeat (150) @(negedge clk_i);
    chk(!out_valid_o, "R4 dropped word absent", out_valid_o, 0);

    // R2 streaming patterns
    for (int i = 0; i < 40; i++)
      push_word((DW'(1) << (i % DW)) ^ ((i % 2) ? 18'h3_FFFF : 18'h0));
    wait_drain("R2 stream");

    // R8/R9/R10 host to device, 100 words
    dev_write_i = 1;
    load_wc(100);
    for (int i = 0; i < 65; i++) push_word(DW'(i * 77 + 300));
    repeat (150) @(negedge clk_i);
    chk(obuf_full_o, "R8 obuf holds word", obuf_full_o, 1);
    chk(!out_valid_o, "R8 output held during prefill", out_valid_o, 0);
    for (int i = 65; i < 99; i++) push_word(DW'(i * 77 + 300));
    chk(!host_ovf_o, "R10 host_ovf before last", host_ovf_o, 0);
    push_word(DW'(99 * 77 + 300));
    chk(host_ovf_o, "R10 host_ovf on 100th", host_ovf_o, 1);
    chk(!dev_done_o, "R10 device still busy", dev_done_o, 0);
    wait_drain("R8 drain after prefill");
    repeat (2) @(negedge clk_i);
    chk(dev_done_o, "R9 dev_done after 100 taken", dev_done_o, 1);

    // R8 short transfer released by host wrap
    load_wc(10);
    chk(!dev_done_o && !host_ovf_o, "R9 load clears flags", {host_ovf_o, dev_done_o}, 0);
    for (int i = 0; i < 10; i++) push_word(DW'(i + 18'h1_0000));
    wait_drain("R8 short transfer released");
    repeat (2) @(negedge clk_i);
    chk(dev_done_o, "R9 short dev_done", dev_done_o, 1);

    // R9/R10 device to host
    dev_write_i = 0; drain_en = 0;
    load_wc(5);
    for (int i = 0; i < 4; i++) push_word(DW'(i + 18'h0_0ABC));
    chk(!dev_done_o, "R9 dev_done before 5th", dev_done_o, 0);
    push_word(18'h0_0ABF + 18'h1);
    chk(dev_done_o, "R9 dev_done on 5th push", dev_done_o, 1);
    chk(!host_ovf_o, "R10 host_ovf before reads", host_ovf_o, 0);
    drain_en = 1;
    wait_drain("R10 drain dev to host");
    repeat (2) @(negedge clk_i);
    chk(host_ovf_o, "R10 host_ovf after 5 reads", host_ovf_o, 1);

    // R11 clear
    drain_en = 0;
    for (int i = 0; i < 20; i++) push_word(DW'(i + 18'h2_2000));
    repeat (30) @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    q.delete();
    chk(!ibuf_full_o && !obuf_full_o, "R11 holding regs empty", {ibuf_full_o, obuf_full_o}, 0);
    chk(silo_in_rdy_o && !silo_out_rdy_o, "R11 cells empty", {silo_in_rdy_o, silo_out_rdy_o}, 2'b10);
    chk(!host_ovf_o && !dev_done_o, "R11 counter flags", {host_ovf_o, dev_done_o}, 0);
    repeat (100) @(negedge clk_i);
    chk(!out_valid_o, "R11 old words gone", out_valid_o, 0);
    drain_en = 1;
    push_word(18'h1_2345);
    wait_drain("R11 word after clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule